// File: doc/BRIEF.md
# Unassigned-Page Write Capture Queue

This block is the bus target for logical memory pages that have no physical page assigned. Any read that lands in such a page gets the byte 0x00. Each write that lands there is not lost: the block packs the 16-bit logical address and the 8-bit write data into a record and puts it into a first-in, first-out queue. The queue is deep enough to hold every byte that one faulting instruction can write in the worst case. That case is a full register save of 12 bytes followed by 12 bytes of interrupt stacking.

While records wait in the queue, the block raises a page-fault interrupt request. The request does not rise in the middle of an instruction. It rises at the next instruction-end strobe, so the faulting instruction finishes first. Supervisor code then reads the records one at a time through a valid/ready output stream, or throws them all away with the clear input. It must do this before the faulting task touches that memory again.

On the output stream, `head_valid_o` is high whenever a record is waiting, and the record is shown on the head outputs with no delay. A record leaves the queue on a clock edge where both `head_valid_o` and `head_ready_i` are high. The write side cannot be held back, because a bus write cannot be stalled. A write that finds the queue full is dropped, and this is recorded in a sticky overflow flag.

Top module: `pgfault_capture`

## Requirements
- R1: While `sel_i` is high and `wr_i` is low (a read), `rdata_o` is 0x00.
- R2: A clock edge with `sel_i` and `wr_i` both high stores the record {address, data}. Records leave in the order they were stored. The head outputs show the oldest record.
- R3: A write with `sel_i` low, or any read, stores nothing.
- R4: `count_o` gives the number of stored records (0 to 24). `empty_o` and `head_valid_o` reflect that number: `empty_o` is high and `head_valid_o` is low exactly when the count is 0.
- R5: A clock edge with `head_valid_o` and `head_ready_i` both high removes the head record. `head_ready_i` has no effect while the queue is empty.
- R6: A write and a pop on the same edge leave the count unchanged. This holds even when the queue is full, in which case the write is accepted.
- R7: The queue holds 24 records. A write that finds 24 records stored and no pop on the same edge is dropped, and it sets `overflow_o`.
- R8: `overflow_o` stays high until the clear input is applied. Pops do not lower it, and neither does draining the queue.
- R9: A clock edge with `clr_i` high empties the queue, lowers `overflow_o` and lowers `irq_o`. Clear wins over a write or a pop on the same edge.
- R10: `irq_o` rises only after an edge where `insn_end_i` is high and the queue is non-empty once that edge completes. It then stays high until the queue becomes empty.
- R11: After reset the queue is empty, and `overflow_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Access targets an unassigned page |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Logical address of the access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, always 0x00 |
| insn_end_i | input | 1 | Last cycle of the current instruction |
| clr_i | input | 1 | Flush the queue and the overflow flag |
| head_valid_o | output | 1 | A record is waiting at the head |
| head_ready_i | input | 1 | Consumer accepts the head record |
| head_addr_o | output | 16 | Address field of the head record |
| head_data_o | output | 8 | Data field of the head record |
| count_o | output | 5 | Number of stored records |
| empty_o | output | 1 | No records stored |
| overflow_o | output | 1 | Sticky flag: a write was dropped |
| irq_o | output | 1 | Page-fault interrupt request (level) |

## Verification
The assertions make only one assumption about the inputs: that they are at known values after reset. They let `head_ready_i` be high while the queue is empty, let `clr_i` coincide with any other stimulus, and let `insn_end_i` pulse at any time. The bench changes every input only on the falling clock edge, so each input is steady across the rising edge that samples it. The bench deliberately drives the awkward combinations: a pop on an empty queue, a write and a pop together on a full queue, a write in the same cycle as an instruction end, and a clear while records are queued.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int PF_AW = 16;
  localparam int PF_DW = 8;

  typedef struct packed {
    logic [PF_AW-1:0] addr;
    logic [PF_DW-1:0] data;
  } pf_rec_t;
endpackage

// File: rtl/pf_decode.sv
module pf_decode
  import pf_pkg::*;
(
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [PF_AW-1:0] addr_i,
  input  logic [PF_DW-1:0] wdata_i,
  output logic             push_o,
  output pf_rec_t          rec_o,
  output logic [PF_DW-1:0] rdata_o
);
  // Only writes into the unmapped region are logged.
  assign push_o     = sel_i & wr_i;
  assign rec_o.addr = addr_i;
  assign rec_o.data = wdata_i;
  // Unmapped pages read as zero.
  assign rdata_o    = '0;
endmodule

// File: rtl/pf_fifo.sv
module pf_fifo
  import pf_pkg::*;
#(
  parameter int DEPTH = 24,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  pf_rec_t       rec_i,
  input  logic          pop_i,
  output pf_rec_t       head_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          empty_o,
  output logic          ovf_o
);
  pf_rec_t       mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q;
  logic          full, empty, do_push, do_pop, drop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop_i & ~empty;
  // When full, a write is accepted only if a pop frees a slot on the same edge.
  assign do_push = push_i & (~full | do_pop);
  assign drop    = push_i & full & ~do_pop;

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_d;
      if (drop) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr_i) mem_q[wr_ptr_q] <= rec_i;
  end

  assign head_o    = mem_q[rd_ptr_q];
  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
  assign empty_o   = empty;
  assign ovf_o     = ovf_q;

  // R7: occupancy never exceeds the depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R6: a write and a pop on one edge keep the count
  a_r6_push_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !empty && !clr_i) |=> $stable(cnt_q));
  // R5: a pop request on an empty queue does nothing
  a_r5_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty && !push_i && !clr_i) |=> (cnt_q == '0));
  // R8: the overflow flag falls only on clear
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_i) |=> ovf_q);
  // R9: clear empties the queue
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0 && !ovf_q));
endmodule

// File: rtl/pf_irq.sv
module pf_irq #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          insn_end_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cnt_nxt_i,
  output logic          irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (clr_i) irq_q <= 1'b0;
    else            irq_q <= (cnt_nxt_i != '0) && (irq_q || insn_end_i);
  end

  assign irq_o = irq_q;

  // R10: the request only rises at an instruction end
  a_r10_rise_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && !insn_end_i) |=> !irq_q);
  // R10: the request is never high while the queue is empty
  a_r10_irq_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (cnt_i != '0));
endmodule

// File: rtl/pgfault_capture.sv
module pgfault_capture
  import pf_pkg::*;
#(
  parameter int DEPTH = 24,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [PF_AW-1:0] addr_i,
  input  logic [PF_DW-1:0] wdata_i,
  output logic [PF_DW-1:0] rdata_o,
  input  logic             insn_end_i,
  input  logic             clr_i,
  output logic             head_valid_o,
  input  logic             head_ready_i,
  output logic [PF_AW-1:0] head_addr_o,
  output logic [PF_DW-1:0] head_data_o,
  output logic [CW-1:0]    count_o,
  output logic             empty_o,
  output logic             overflow_o,
  output logic             irq_o
);
  logic          push;
  pf_rec_t       rec, head;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          empty;

  pf_decode u_dec (
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .push_o  (push),
    .rec_o   (rec),
    .rdata_o (rdata_o)
  );

  pf_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .push_i    (push),
    .rec_i     (rec),
    .pop_i     (head_ready_i),
    .head_o    (head),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .empty_o   (empty),
    .ovf_o     (overflow_o)
  );

  pf_irq #(.CW(CW)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .insn_end_i (insn_end_i),
    .cnt_i      (cnt),
    .cnt_nxt_i  (cnt_nxt),
    .irq_o      (irq_o)
  );

  assign head_valid_o = ~empty;
  assign empty_o      = empty;
  assign count_o      = cnt;
  assign head_addr_o  = head.addr;
  assign head_data_o  = head.data;

  // R4: the stream valid is the complement of empty
  a_r4_valid_empty: assert property (@(posedge clk) disable iff (!rst_n)
    head_valid_o == (count_o != '0));
endmodule

// File: tb/test_pgfault_capture.sv
module test_pgfault_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_i = 0, wr_i = 0, insn_end_i = 0, clr_i = 0, head_ready_i = 0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o, head_data_o;
  logic [15:0] head_addr_o;
  logic [4:0]  count_o;
  logic        head_valid_o, empty_o, overflow_o, irq_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [23:0] model [$];

  always #4 clk = ~clk;

  pgfault_capture i_pgfault_capture (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .insn_end_i(insn_end_i), .clr_i(clr_i),
    .head_valid_o(head_valid_o), .head_ready_i(head_ready_i),
    .head_addr_o(head_addr_o), .head_data_o(head_data_o), .count_o(count_o),
    .empty_o(empty_o), .overflow_o(overflow_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {sel,wr,ie,pop,clr, addr16, data8, exp_cnt5, exp_irq, exp_haddr16, exp_hdata8}
  localparam int VW = 59;
  localparam int NV = 13;
  localparam logic [VW-1:0] VEC [NV] = '{
    {5'b10000, 16'h1234, 8'h00, 5'd0, 1'b0, 16'h0000, 8'h00}, // R1 R3 read
    {5'b01000, 16'h2000, 8'h55, 5'd0, 1'b0, 16'h0000, 8'h00}, // R3 unselected
    {5'b11000, 16'h8001, 8'hA1, 5'd1, 1'b0, 16'h8001, 8'hA1}, // R2
    {5'b11000, 16'h8002, 8'hA2, 5'd2, 1'b0, 16'h8001, 8'hA1}, // R2 order
    {5'b00100, 16'h0000, 8'h00, 5'd2, 1'b1, 16'h8001, 8'hA1}, // R10 rise
    {5'b00000, 16'h0000, 8'h00, 5'd2, 1'b1, 16'h8001, 8'hA1}, // R10 level
    {5'b00010, 16'h0000, 8'h00, 5'd1, 1'b1, 16'h8002, 8'hA2}, // R5 pop
    {5'b11010, 16'h8003, 8'hA3, 5'd1, 1'b1, 16'h8003, 8'hA3}, // R6
    {5'b00010, 16'h0000, 8'h00, 5'd0, 1'b0, 16'h0000, 8'h00}, // R10 fall
    {5'b00010, 16'h0000, 8'h00, 5'd0, 1'b0, 16'h0000, 8'h00}, // R5 empty pop
    {5'b11100, 16'h9000, 8'h11, 5'd1, 1'b1, 16'h9000, 8'h11}, // R10 same cycle
    {5'b11011, 16'h9001, 8'h22, 5'd0, 1'b0, 16'h0000, 8'h00}, // R9 priority
    {5'b00100, 16'h0000, 8'h00, 5'd0, 1'b0, 16'h0000, 8'h00}  // R10 empty
  };

  task automatic idle();
    sel_i = 0; wr_i = 0; insn_end_i = 0; head_ready_i = 0; clr_i = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic pop);
    sel_i = 1; wr_i = 1; addr_i = a; wdata_i = d; head_ready_i = pop;
    @(negedge clk);
    idle();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 count", count_o, 0);
    chk("R11 empty", empty_o, 1);
    chk("R11 ovf", overflow_o, 0);
    chk("R11 irq", irq_o, 0);
    chk("R4 valid", head_valid_o, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      {sel_i, wr_i, insn_end_i, head_ready_i, clr_i} = v[58:54];
      addr_i = v[53:38];
      wdata_i = v[37:30];
      #1;
      if (sel_i && !wr_i) chk("R1 rdata", rdata_o, 8'h00);
      @(negedge clk);
      idle();
      chk($sformatf("R4 count v%0d", i), count_o, v[29:25]);
      chk($sformatf("R10 irq v%0d", i), irq_o, v[24]);
      chk($sformatf("R4 empty v%0d", i), empty_o, v[29:25] == 0);
      if (v[29:25] != 0)
        chk($sformatf("R2 head v%0d", i), {head_addr_o, head_data_o}, v[23:0]);
    end

    // R7 fill to depth
    for (int k = 0; k < 24; k++) begin
      wr(16'hC000 + 16'(k), 8'(k * 3), 1'b0);
      model.push_back({16'hC000 + 16'(k), 8'(k * 3)});
    end
    chk("R7 full count", count_o, 24);
    chk("R7 no ovf yet", overflow_o, 0);
    wr(16'hDEAD, 8'hEE, 1'b0);
    chk("R7 drop count", count_o, 24);
    chk("R7 ovf set", overflow_o, 1);
    chk("R7 head kept", {head_addr_o, head_data_o}, model[0]);
    // R6 write and pop together while full
    wr(16'hBEEF, 8'h77, 1'b1);
    void'(model.pop_front());
    model.push_back({16'hBEEF, 8'h77});
    chk("R6 full push+pop count", count_o, 24);
    // R2 R5 drain in order
    for (int k = 0; k < 24; k++) begin
      chk($sformatf("R2 drain %0d", k), {head_addr_o, head_data_o}, model.pop_front());
      head_ready_i = 1;
      @(negedge clk);
      idle();
    end
    chk("R5 drained", empty_o, 1);
    chk("R8 ovf after drain", overflow_o, 1);
    chk("R10 no strobe no irq", irq_o, 0);
    clr_i = 1;
    @(negedge clk);
    idle();
    chk("R9 ovf cleared", overflow_o, 0);

    // R11 reset mid-run
    wr(16'h4444, 8'h44, 1'b0);
    insn_end_i = 1;
    @(negedge clk);
    idle();
    chk("R10 irq before reset", irq_o, 1);
    rst_n = 0;
    @(negedge clk);
    chk("R11 reset count", count_o, 0);
    chk("R11 reset irq", irq_o, 0);
    rst_n = 1;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule